// File: doc/BRIEF.md
# Counter Enable Permission Checker

This block decides, in the same cycle, whether a control-register access that touches the performance counter space is allowed. It takes the current privilege level, a 12-bit register address, a write flag and the two mode-support bits that say whether user and supervisor modes exist. It raises an illegal-instruction flag when the access is not allowed.

The block holds two counter-enable registers. The machine-level one sits at address 0x306 and the supervisor-level one at 0x106. Bit i of each register governs counter i, which is read at address 0xC00 + i for i from 0 to 31. Each register drops every bit that a parameter marks as not implemented, so those bits read as zero forever and the matching counter can never be read from a lower level. The counters themselves, trap entry and every other control register are handled elsewhere. The address 0xC00–0xC1F is only checked here and returns zero data.

Privilege is encoded on `acc_priv` as 0 = user, 1 = supervisor, 3 = machine. The reserved value 2 is treated as user.

Top module: `ctrperm_top`

## Requirements
- R1: After reset, both enable registers are zero, and legal machine-mode reads of 0x306 and 0x106 return zero.
- R2: A legal machine-mode write to 0x306 stores the write data ANDed with `M_IMPL_MASK`. The new value is visible on reads in the following cycle. A legal access to 0x306 returns the stored value on `rd_data` in the same cycle.
- R3: A legal write to 0x106 from machine or supervisor mode stores the write data ANDed with `S_IMPL_MASK`. The new value is visible in the following cycle. A legal access returns the stored value in the same cycle.
- R4: Any write to 0xC00–0xC1F is illegal at every privilege level and changes neither enable register.
- R5: A machine-mode read of 0xC00–0xC1F is always legal.
- R6: A supervisor-mode read of counter i is legal exactly when machine enable bit i is 1.
- R7: With supervisor mode present (`misa_s`=1), a user-mode read of counter i is legal exactly when both machine enable bit i and supervisor enable bit i are 1.
- R8: With supervisor mode absent (`misa_s`=0), a user-mode read of counter i is legal exactly when machine enable bit i is 1. Any access to 0x106 is illegal in that case.
- R9: Access to 0x306 is illegal below machine mode or when `misa_u`=0. Access to 0x106 is illegal from user mode. An illegal access changes no state and returns zero on `rd_data`.
- R10: `illegal` and `rd_data` follow the inputs of the current cycle, with no register delay.
- R11: An access to any other address, or any cycle with `acc_valid`=0, gives `illegal`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| acc_addr | input | 12 | Register address |
| acc_write | input | 1 | 1 for a write access |
| acc_wdata | input | 32 | Write data |
| misa_u | input | 1 | User mode is supported |
| misa_s | input | 1 | Supervisor mode is supported |
| rd_data | output | 32 | Read data for the enable registers, zero otherwise |
| illegal | output | 1 | Access must raise an illegal-instruction exception |

## Verification
The legality flag and read data depend only on the current inputs and the stored enables, so they are due in the same cycle as the access. The bench drives each access on a falling edge and samples two nanoseconds later, before the next rising edge. A write that is allowed is committed on the following rising edge. The bench model therefore applies it only after that cycle's checks, and every later access is compared against the updated value.

// File: rtl/ctrperm_pkg.sv
package ctrperm_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned NCTR    = 32;
    localparam int unsigned IDX_W   = $clog2(NCTR);

    localparam logic [ADDR_W-1:0] ADDR_MEN  = 12'h306;
    localparam logic [ADDR_W-1:0] ADDR_SEN  = 12'h106;
    localparam logic [ADDR_W-1:0] ADDR_CTR0 = 12'hC00;

    typedef struct packed {
        logic             is_ctr;
        logic             is_men;
        logic             is_sen;
        logic [IDX_W-1:0] idx;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.is_ctr = (a[ADDR_W-1:IDX_W] == ADDR_CTR0[ADDR_W-1:IDX_W]);
        d.is_men = (a == ADDR_MEN);
        d.is_sen = (a == ADDR_SEN);
        d.idx    = a[IDX_W-1:0];
        return d;
    endfunction

    function automatic priv_e eff_priv(input logic [1:0] p);
        return (p == PRIV_RSVD) ? PRIV_U : priv_e'(p);
    endfunction

endpackage

// File: rtl/ctrperm_warl_reg.sv
module ctrperm_warl_reg
    import ctrperm_pkg::*;
#(
    parameter logic [NCTR-1:0] IMPL_MASK = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NCTR-1:0] wr_data,
    output logic [NCTR-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wr_data & IMPL_MASK;
    end

    // R2/R3: unimplemented bits never hold a one
    assert_hardwired_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (q & ~IMPL_MASK) == '0);

    // R1: register is zero right after reset
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> q == '0);

endmodule

// File: rtl/ctrperm_rule.sv
module ctrperm_rule
    import ctrperm_pkg::*;
(
    input  logic [1:0]        priv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              misa_u,
    input  logic              misa_s,
    input  logic [NCTR-1:0]   men,
    input  logic [NCTR-1:0]   sen,
    output logic              deny,
    output logic              hit_men,
    output logic              hit_sen
);

    addr_dec_t dec;
    priv_e     p;
    logic      ctr_ok;

    always_comb begin
        dec = decode_addr(addr);
        p   = eff_priv(priv);
        unique case (p)
            PRIV_M:  ctr_ok = 1'b1;
            PRIV_S:  ctr_ok = men[dec.idx];
            default: ctr_ok = misa_s ? (men[dec.idx] & sen[dec.idx])
                                     : men[dec.idx];
        endcase
    end

    always_comb begin
        deny = 1'b0;
        if (dec.is_ctr)
            deny = write | ~ctr_ok;
        else if (dec.is_men)
            deny = (p != PRIV_M) | ~misa_u;
        else if (dec.is_sen)
            deny = ~misa_s | (p == PRIV_U);
    end

    assign hit_men = dec.is_men;
    assign hit_sen = dec.is_sen;

endmodule

// File: rtl/ctrperm_top.sv
module ctrperm_top
    import ctrperm_pkg::*;
#(
    parameter logic [31:0] M_IMPL_MASK = 32'hFFFF_FFF7,
    parameter logic [31:0] S_IMPL_MASK = 32'h0000_FFFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic [1:0]  acc_priv,
    input  logic [11:0] acc_addr,
    input  logic        acc_write,
    input  logic [31:0] acc_wdata,
    input  logic        misa_u,
    input  logic        misa_s,
    output logic [31:0] rd_data,
    output logic        illegal
);

    logic [NCTR-1:0] men_q, sen_q;
    logic            deny, hit_men, hit_sen;
    logic            ok;

    ctrperm_rule u_rule (
        .priv    (acc_priv),
        .addr    (acc_addr),
        .write   (acc_write),
        .misa_u  (misa_u),
        .misa_s  (misa_s),
        .men     (men_q),
        .sen     (sen_q),
        .deny    (deny),
        .hit_men (hit_men),
        .hit_sen (hit_sen)
    );

    assign ok      = acc_valid & ~deny;
    assign illegal = acc_valid & deny;

    ctrperm_warl_reg #(.IMPL_MASK(M_IMPL_MASK)) u_men (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ok & acc_write & hit_men),
        .wr_data (acc_wdata),
        .q       (men_q)
    );

    ctrperm_warl_reg #(.IMPL_MASK(S_IMPL_MASK)) u_sen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ok & acc_write & hit_sen),
        .wr_data (acc_wdata),
        .q       (sen_q)
    );

    always_comb begin
        rd_data = '0;
        if (ok && hit_men)      rd_data = men_q;
        else if (ok && hit_sen) rd_data = sen_q;
    end

    // R4: a counter write is always flagged
    assert_ctr_write_illegal_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_addr[11:5] == 7'h60) |-> illegal);

    // R9: a flagged access leaves both enables untouched
    assert_illegal_no_update_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |=> ($stable(men_q) && $stable(sen_q)));

    // R7: a user counter read that passes needs the machine enable bit
    assert_user_needs_men_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv == 2'd0 && !acc_write && acc_addr[11:5] == 7'h60 && !illegal)
        |-> men_q[acc_addr[4:0]]);

    // R11: no access, no flag and no data
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!illegal && rd_data == '0));

endmodule

// File: tb/ctrperm_top_tb_top.sv
module ctrperm_top_tb_top;

    localparam logic [31:0] MM = 32'hFFFF_FFF7;
    localparam logic [31:0] SM = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [1:0]  acc_priv;
    logic [11:0] acc_addr;
    logic        acc_write;
    logic [31:0] acc_wdata;
    logic        misa_u, misa_s;
    logic [31:0] rd_data;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_men = '0;
    logic [31:0] m_sen = '0;

    always #4 clk = ~clk;

    ctrperm_top #(.M_IMPL_MASK(MM), .S_IMPL_MASK(SM)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_priv(acc_priv),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .misa_u(misa_u), .misa_s(misa_s), .rd_data(rd_data), .illegal(illegal)
    );

    function automatic logic exp_illegal(logic v, logic [1:0] pr, logic [11:0] a,
                                         logic w, logic mu, logic ms);
        logic [1:0] p = (pr == 2'd2) ? 2'd0 : pr;
        logic [4:0] i = a[4:0];
        if (!v) return 1'b0;
        if (a[11:5] == 7'h60) begin
            if (w) return 1'b1;
            if (p == 2'd3) return 1'b0;
            if (p == 2'd1) return !m_men[i];
            return ms ? !(m_men[i] && m_sen[i]) : !m_men[i];
        end
        if (a == 12'h306) return (p != 2'd3) || !mu;
        if (a == 12'h106) return !ms || (p == 2'd0);
        return 1'b0;
    endfunction

    function automatic string tag_of(logic v, logic [1:0] pr, logic [11:0] a,
                                     logic w, logic ms, logic ill);
        logic [1:0] p = (pr == 2'd2) ? 2'd0 : pr;
        if (!v) return "R11";
        if (a[11:5] == 7'h60) begin
            if (w) return "R4";
            if (p == 2'd3) return "R5";
            if (p == 2'd1) return "R6";
            return ms ? "R7" : "R8";
        end
        if (a == 12'h106 && !ms) return "R8";
        if (a == 12'h306) return ill ? "R9" : "R2";
        if (a == 12'h106) return ill ? "R9" : "R3";
        return "R11";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R10: outputs sampled in the same cycle the access is driven
    task automatic access(logic v, logic [1:0] pr, logic [11:0] a, logic w,
                          logic [31:0] d, logic mu, logic ms);
        logic        ei;
        logic [31:0] ed;
        string       t;
        @(negedge clk);
        acc_valid = v; acc_priv = pr; acc_addr = a; acc_write = w;
        acc_wdata = d; misa_u = mu; misa_s = ms;
        #2;
        ei = exp_illegal(v, pr, a, w, mu, ms);
        ed = '0;
        if (v && !ei && a == 12'h306) ed = m_men;
        if (v && !ei && a == 12'h106) ed = m_sen;
        t = tag_of(v, pr, a, w, ms, ei);
        chk({t, " illegal R10"}, {31'd0, illegal}, {31'd0, ei});
        chk({t, " rd_data"}, rd_data, ed);
        if (v && !ei && w && a == 12'h306) m_men = d & MM;
        if (v && !ei && w && a == 12'h106) m_sen = d & SM;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; acc_valid = 0; acc_priv = 0; acc_addr = 0; acc_write = 0;
        acc_wdata = 0; misa_u = 1; misa_s = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state read back
        access(1, 2'd3, 12'h306, 0, 0, 1, 1);
        access(1, 2'd3, 12'h106, 0, 0, 1, 1);
        chk("R1 reset men", m_men, 32'd0);
        // R5/R6/R7 with all enables clear
        access(1, 2'd3, 12'hC00, 0, 0, 1, 1);
        access(1, 2'd1, 12'hC01, 0, 0, 1, 1);
        access(1, 2'd0, 12'hC02, 0, 0, 1, 1);
        // R2: all-ones write, hardwired bit 3 drops
        access(1, 2'd3, 12'h306, 1, 32'hFFFF_FFFF, 1, 1);
        access(1, 2'd3, 12'h306, 0, 0, 1, 1);
        // R6: hardwired counter 3 stays illegal from supervisor
        access(1, 2'd1, 12'hC03, 0, 0, 1, 1);
        access(1, 2'd1, 12'hC04, 0, 0, 1, 1);
        // R7: user needs supervisor bit too
        access(1, 2'd0, 12'hC04, 0, 0, 1, 1);
        access(1, 2'd1, 12'h106, 1, 32'hFFFF_FFFF, 1, 1);
        access(1, 2'd0, 12'hC04, 0, 0, 1, 1);
        access(1, 2'd0, 12'hC1F, 0, 0, 1, 1);
        // R8: no supervisor mode
        access(1, 2'd0, 12'hC1F, 0, 0, 1, 0);
        access(1, 2'd3, 12'h106, 0, 0, 1, 0);
        // R4: counter write illegal and no state change
        access(1, 2'd3, 12'hC05, 1, 32'h0, 1, 1);
        access(1, 2'd3, 12'h306, 0, 0, 1, 1);
        // R9: privilege too low
        access(1, 2'd1, 12'h306, 1, 32'h0, 1, 1);
        access(1, 2'd0, 12'h106, 1, 32'h0, 1, 1);
        access(1, 2'd3, 12'h306, 0, 0, 0, 1);
        // R11: idle and unrelated addresses
        access(0, 2'd3, 12'h306, 0, 0, 1, 1);
        access(1, 2'd0, 12'h123, 1, 32'hFFFF_FFFF, 1, 1);

        for (int k = 0; k < 2000; k++) begin
            logic [1:0]  pr;
            logic [11:0] a;
            logic [2:0]  sel = 3'($urandom_range(0, 7));
            pr = 2'($urandom_range(0, 3));
            if (sel < 3'd4)       a = 12'hC00 | 12'($urandom_range(0, 31));
            else if (sel == 3'd4) a = 12'h306;
            else if (sel == 3'd5) a = 12'h106;
            else                  a = 12'($urandom);
            access(($urandom_range(0, 9) != 0), pr, a, ($urandom_range(0, 2) == 0),
                   $urandom, ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) != 0));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule